// File: doc/BRIEF.md
# Two-Channel Pulse Counter Host Register File

This block sits between a simple synchronous host bus and the core of a two-channel 24-bit pulse counter. The host reads and writes 16-bit words. Each channel has a preset value, a mode byte and a target (set) value, which the block holds and drives to the counter core. It also has a present-value snapshot that the host reads back. Each 24-bit quantity is split into a lower 16-bit word and an upper word that carries only 8 meaningful bits.

Each channel has a per-channel read-request line. The block freezes the running count of that channel on the rising edge of this line, so the two halves the host reads belong to the same instant. When the host writes either word of a target value, the block sends a one-cycle notice to the counter core.

Top module: `pcnt_hostregs`

## Requirements
- R1: After reset, every held register is zero: the preset, mode, target and snapshot of both channels. `preset_o`, `target_o`, `mode_o` and `target_chg` read zero, and a mode read returns 0.
- R2: The top address bit picks the channel. Channel 0 answers at word addresses 1..7 and channel 1 at 33..39, with the same offset layout in both. An access to one channel leaves the other unchanged.
- R3: Offset 1 (preset bits 15:0) and offset 2 (preset bits 23:16) are write-only. They drive `preset_o`, and a read of either returns 0.
- R4: Offset 3 is the read/write mode byte, driven on `mode_o`. Code 8 selects single-phase counting and code 18 (0x12) selects two-phase counting. Write-data bits 15:8 are dropped, and a read returns the byte in bits 7:0 with zeros above.
- R5: Offset 6 (target bits 15:0) and offset 7 (target bits 23:16) are read/write and drive `target_o`.
- R6: For every upper word (offsets 2, 5 and 7), only write-data bits 7:0 are kept, and read-data bits 15:8 are zero.
- R7: On a rising edge of `pv_req[c]`, the block copies `live_cnt` of channel c into its snapshot. The snapshot stays frozen while the line stays high or low, until the next rising edge. Offset 4 returns snapshot bits 15:0 and offset 5 returns bits 23:16.
- R8: Reads of unmapped addresses (offset 0, offsets 8..31, and any channel index of 2 or more) return 0. Writes to those addresses, and writes to offsets 4 and 5, change nothing.
- R9: A write to offset 6 or 7 of channel c raises `target_chg[c]` for exactly the one cycle after the write edge. No write means no pulse.
- R10: Read data appears on `rdata` in the cycle after the edge that samples `rd_en`. In a cycle where `rd_en` was low at that edge, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 6 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| live_cnt | input | 48 | Running count, channel c in bits 24c+23..24c |
| pv_req | input | 2 | Per-channel snapshot request, acts on its rising edge |
| preset_o | output | 48 | Preset value per channel |
| target_o | output | 48 | Target (set) value per channel |
| mode_o | output | 16 | Mode byte per channel |
| target_chg | output | 2 | One-cycle pulse after a target write |

## Verification
The assertions assume three things about the inputs:
- `wr_en` and `rd_en` are never high together.
- The bus stays idle until the internal reset release has finished.
- `addr` and `wdata` are stable at the sampling edge.

The bench drives one strobe at a time, one cycle after a clock edge, with an idle cycle between accesses. It waits several cycles after reset before the first access. It changes `live_cnt` only after the snapshot edge it wants to test, so a frozen value and a newly taken one can be told apart.

// File: rtl/pcnt_hr_pkg.sv
package pcnt_hr_pkg;
  localparam int CNT_W  = 24;
  localparam int WORD_W = 16;
  localparam int HI_W   = CNT_W - WORD_W;
  localparam int MODE_W = 8;
  localparam int OFF_W  = 3;

  typedef enum logic [OFF_W-1:0] {
    OFF_NONE  = 3'd0,
    OFF_PR_LO = 3'd1,
    OFF_PR_HI = 3'd2,
    OFF_MODE  = 3'd3,
    OFF_PV_LO = 3'd4,
    OFF_PV_HI = 3'd5,
    OFF_TG_LO = 3'd6,
    OFF_TG_HI = 3'd7
  } hr_off_e;
endpackage

// File: rtl/pcnt_rst_sync.sv
module pcnt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pcnt_chan_regs.sv
module pcnt_chan_regs
  import pcnt_hr_pkg::*;
(
  input  logic              clk,
  input  logic              arst_n,
  input  logic              wr_hit,
  input  hr_off_e           off,
  input  logic [WORD_W-1:0] wdata,
  input  logic              pv_req,
  input  logic [CNT_W-1:0]  live,
  output logic [CNT_W-1:0]  preset_o,
  output logic [CNT_W-1:0]  target_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              target_chg,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] pr_lo_q, pr_lo_d, tg_lo_q, tg_lo_d;
  logic [HI_W-1:0]   pr_hi_q, pr_hi_d, tg_hi_q, tg_hi_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic [CNT_W-1:0]  snap_q, snap_d;
  logic              req_q, chg_q, chg_d;
  logic              snap_en;

  always_comb begin
    pr_lo_d = pr_lo_q;
    pr_hi_d = pr_hi_q;
    tg_lo_d = tg_lo_q;
    tg_hi_d = tg_hi_q;
    mode_d  = mode_q;
    if (wr_hit) begin
      case (off)
        OFF_PR_LO: pr_lo_d = wdata;
        OFF_PR_HI: pr_hi_d = wdata[HI_W-1:0];
        OFF_MODE:  mode_d  = wdata[MODE_W-1:0];
        OFF_TG_LO: tg_lo_d = wdata;
        OFF_TG_HI: tg_hi_d = wdata[HI_W-1:0];
        default:   ;
      endcase
    end
    chg_d   = wr_hit && (off == OFF_TG_LO || off == OFF_TG_HI);
    snap_en = pv_req && !req_q;
    snap_d  = snap_en ? live : snap_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pr_lo_q <= '0;
      pr_hi_q <= '0;
      tg_lo_q <= '0;
      tg_hi_q <= '0;
      mode_q  <= '0;
      snap_q  <= '0;
      req_q   <= 1'b0;
      chg_q   <= 1'b0;
    end else begin
      pr_lo_q <= pr_lo_d;
      pr_hi_q <= pr_hi_d;
      tg_lo_q <= tg_lo_d;
      tg_hi_q <= tg_hi_d;
      mode_q  <= mode_d;
      snap_q  <= snap_d;
      req_q   <= pv_req;
      chg_q   <= chg_d;
    end
  end

  always_comb begin
    case (off)
      OFF_MODE:  rd_word = {{(WORD_W-MODE_W){1'b0}}, mode_q};
      OFF_PV_LO: rd_word = snap_q[WORD_W-1:0];
      OFF_PV_HI: rd_word = {{(WORD_W-HI_W){1'b0}}, snap_q[CNT_W-1:WORD_W]};
      OFF_TG_LO: rd_word = tg_lo_q;
      OFF_TG_HI: rd_word = {{(WORD_W-HI_W){1'b0}}, tg_hi_q};
      default:   rd_word = '0;
    endcase
  end

  assign preset_o   = {pr_hi_q, pr_lo_q};
  assign target_o   = {tg_hi_q, tg_lo_q};
  assign mode_o     = mode_q;
  assign target_chg = chg_q;
endmodule

// File: rtl/pcnt_hostregs.sv
module pcnt_hostregs
  import pcnt_hr_pkg::*;
#(
  parameter int NCH        = 2,
  parameter int ADDR_W     = 6,
  parameter int STRIDE_LG2 = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [WORD_W-1:0]      wdata,
  output logic [WORD_W-1:0]      rdata,
  input  logic [NCH*CNT_W-1:0]   live_cnt,
  input  logic [NCH-1:0]         pv_req,
  output logic [NCH*CNT_W-1:0]   preset_o,
  output logic [NCH*CNT_W-1:0]   target_o,
  output logic [NCH*MODE_W-1:0]  mode_o,
  output logic [NCH-1:0]         target_chg
);
  localparam int CH_W = ADDR_W - STRIDE_LG2;
  localparam logic [STRIDE_LG2-1:0] OFF_SPAN = STRIDE_LG2'(8);

  logic                  rst_int_n;
  logic [CH_W-1:0]       ch_sel;
  logic [STRIDE_LG2-1:0] off_full;
  logic                  off_ok;
  hr_off_e               off;
  logic [WORD_W-1:0]     rd_word [NCH];
  logic [WORD_W-1:0]     rdata_d;

  pcnt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  always_comb begin
    ch_sel   = addr[ADDR_W-1:STRIDE_LG2];
    off_full = addr[STRIDE_LG2-1:0];
    off_ok   = (off_full < OFF_SPAN) && (off_full != '0);
    off      = hr_off_e'(off_full[OFF_W-1:0]);
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pcnt_chan_regs u_ch (
      .clk        (clk),
      .arst_n     (rst_int_n),
      .wr_hit     (wr_en && off_ok && (ch_sel == CH_W'(g))),
      .off        (off),
      .wdata      (wdata),
      .pv_req     (pv_req[g]),
      .live       (live_cnt[g*CNT_W +: CNT_W]),
      .preset_o   (preset_o[g*CNT_W +: CNT_W]),
      .target_o   (target_o[g*CNT_W +: CNT_W]),
      .mode_o     (mode_o[g*MODE_W +: MODE_W]),
      .target_chg (target_chg[g]),
      .rd_word    (rd_word[g])
    );
  end

  always_comb begin
    rdata_d = '0;
    if (rd_en && off_ok) begin
      for (int i = 0; i < NCH; i++) begin
        if (ch_sel == CH_W'(i)) rdata_d = rd_word[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rdata <= '0;
    else            rdata <= rdata_d;
  end
endmodule

// File: rtl/pcnt_hostregs_chk.sv
module pcnt_hostregs_chk
  import pcnt_hr_pkg::*;
#(
  parameter int NCH        = 2,
  parameter int ADDR_W     = 6,
  parameter int STRIDE_LG2 = 5
) (
  input logic                  clk,
  input logic                  rst_int_n,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic [ADDR_W-1:0]     addr,
  input logic [WORD_W-1:0]     wdata,
  input logic [WORD_W-1:0]     rdata,
  input logic [NCH*CNT_W-1:0]  preset_o,
  input logic [NCH*CNT_W-1:0]  target_o,
  input logic [NCH*MODE_W-1:0] mode_o,
  input logic [NCH-1:0]        target_chg
);
  assert_unmapped_rd_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_en && addr == '0 |=> rdata == '0);

  assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rd_en |=> rdata == '0);

  assert_chg_idle_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !wr_en |=> target_chg == '0);

  assert_target_hold_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !wr_en |=> $stable(target_o) && $stable(preset_o) && $stable(mode_o));

  for (genvar g = 0; g < NCH; g++) begin : g_a
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(g << STRIDE_LG2);

    assert_preset_lo_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
      wr_en && addr == BASE + ADDR_W'(1) |=>
        preset_o[g*CNT_W +: WORD_W] == $past(wdata));

    assert_wonly_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
      rd_en && addr == BASE + ADDR_W'(2) |=> rdata == '0);

    assert_preset_hi_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
      wr_en && addr == BASE + ADDR_W'(2) |=>
        preset_o[g*CNT_W+WORD_W +: HI_W] == $past(wdata[HI_W-1:0]));

    assert_mode_wr_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
      wr_en && addr == BASE + ADDR_W'(3) |=>
        mode_o[g*MODE_W +: MODE_W] == $past(wdata[MODE_W-1:0]));

    assert_hi_pad_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
      rd_en && (addr == BASE + ADDR_W'(5) || addr == BASE + ADDR_W'(7)) |=>
        rdata[WORD_W-1:HI_W] == '0);

    assert_chg_pulse_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
      wr_en && (addr == BASE + ADDR_W'(6) || addr == BASE + ADDR_W'(7)) |=>
        target_chg[g]);
  end
endmodule

bind pcnt_hostregs pcnt_hostregs_chk #(
  .NCH(NCH), .ADDR_W(ADDR_W), .STRIDE_LG2(STRIDE_LG2)
) u_chk (
  .clk        (clk),
  .rst_int_n  (rst_int_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .wdata      (wdata),
  .rdata      (rdata),
  .preset_o   (preset_o),
  .target_o   (target_o),
  .mode_o     (mode_o),
  .target_chg (target_chg)
);

// File: tb/pcnt_hostregs_test.sv
module pcnt_hostregs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [47:0] live_cnt = '0;
  logic [1:0]  pv_req = '0;
  logic [47:0] preset_o;
  logic [47:0] target_o;
  logic [15:0] mode_o;
  logic [1:0]  target_chg;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  bit          pending = 1'b0;

  always #2.5 clk = ~clk;

  pcnt_hostregs uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .live_cnt(live_cnt), .pv_req(pv_req),
    .preset_o(preset_o), .target_o(target_o), .mode_o(mode_o),
    .target_chg(target_chg)
  );

  task automatic check(string tag, logic [47:0] act, logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, logic [15:0] e, string tag);
    @(posedge clk); #1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // monitor: compares registered read data one cycle after the strobe
  always @(negedge clk) begin
    if (pending) begin
      if (exp_q.size() == 0) check("R10 unexpected read", 48'(rdata), 48'h0);
      else check(tag_q.pop_front(), 48'(rdata), 48'(exp_q.pop_front()));
    end
    pending = rd_en;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    check("R1 preset", preset_o, 48'h0);
    check("R1 target", target_o, 48'h0);
    check("R1 mode", 48'(mode_o), 48'h0);
    check("R1 chg", 48'(target_chg), 48'h0);
    rd(6'd3, 16'h0, "R1 mode ch0 read");
    rd(6'd35, 16'h0, "R1 mode ch1 read");
    rd(6'd4, 16'h0, "R1 snapshot read");

    // R3 / R6 preset
    wr(6'd1, 16'h1234);
    wr(6'd2, 16'hFFCD);
    check("R3 R6 preset ch0", 48'(preset_o[23:0]), 48'hCD1234);
    check("R2 preset ch1 untouched", 48'(preset_o[47:24]), 48'h0);
    rd(6'd1, 16'h0, "R3 write-only lo");
    rd(6'd2, 16'h0, "R3 write-only hi");
    wr(6'd33, 16'h0042);
    check("R2 preset ch1", 48'(preset_o[47:24]), 48'h000042);

    // R4 mode
    wr(6'd3, 16'hAB08);
    rd(6'd3, 16'h0008, "R4 single-phase code");
    wr(6'd35, 16'h0012);
    rd(6'd35, 16'h0012, "R4 two-phase code");
    check("R4 mode_o", 48'(mode_o), 48'h1208);

    // R9 / R5 target
    wr(6'd6, 16'h5678);
    check("R9 pulse ch0", 48'(target_chg), 48'h1);
    tick();
    check("R9 pulse one cycle", 48'(target_chg), 48'h0);
    wr(6'd7, 16'h3C9A);
    check("R9 pulse hi write", 48'(target_chg), 48'h1);
    rd(6'd6, 16'h5678, "R5 target lo");
    rd(6'd7, 16'h009A, "R6 target hi pad");
    check("R5 target ch0", 48'(target_o[23:0]), 48'h9A5678);
    wr(6'd38, 16'h0101);
    check("R2 R9 pulse ch1", 48'(target_chg), 48'h2);
    wr(6'd39, 16'h00EE);
    rd(6'd38, 16'h0101, "R2 target ch1 lo");
    rd(6'd39, 16'h00EE, "R2 target ch1 hi");
    check("R2 target both", target_o, 48'hEE0101_9A5678);

    // R10 idle read data
    tick();
    check("R10 idle rdata", 48'(rdata), 48'h0);

    // R7 snapshot
    live_cnt[23:0] = 24'hAB1234;
    tick();
    pv_req[0] = 1'b1;
    tick();
    live_cnt[23:0] = 24'h000005;
    rd(6'd4, 16'h1234, "R7 snapshot lo");
    rd(6'd5, 16'h00AB, "R7 snapshot hi");
    repeat (2) tick();
    rd(6'd4, 16'h1234, "R7 frozen while high");
    pv_req[0] = 1'b0;
    repeat (2) tick();
    rd(6'd4, 16'h1234, "R7 frozen after fall");
    pv_req[0] = 1'b1;
    tick();
    rd(6'd4, 16'h0005, "R7 new edge lo");
    rd(6'd5, 16'h0000, "R7 new edge hi");
    live_cnt[47:24] = 24'h123456;
    pv_req[1] = 1'b1;
    tick();
    rd(6'd36, 16'h3456, "R7 ch1 lo");
    rd(6'd37, 16'h0012, "R7 ch1 hi");
    rd(6'd4, 16'h0005, "R2 ch0 snapshot kept");

    // R8 read-only and unmapped
    wr(6'd4, 16'hFFFF);
    wr(6'd37, 16'hFFFF);
    rd(6'd4, 16'h0005, "R8 read-only lo");
    rd(6'd37, 16'h0012, "R8 read-only hi");
    wr(6'd0, 16'hFFFF);
    wr(6'd8, 16'hFFFF);
    wr(6'd40, 16'hFFFF);
    wr(6'd63, 16'hFFFF);
    wr(6'd32, 16'hFFFF);
    check("R8 preset kept", preset_o, 48'h000042_CD1234);
    check("R8 target kept", target_o, 48'hEE0101_9A5678);
    check("R8 mode kept", 48'(mode_o), 48'h1208);
    check("R8 no pulse", 48'(target_chg), 48'h0);
    rd(6'd0, 16'h0, "R8 unmapped 0");
    rd(6'd8, 16'h0, "R8 unmapped 8");
    rd(6'd32, 16'h0, "R8 unmapped 32");
    rd(6'd40, 16'h0, "R8 unmapped 40");
    rd(6'd63, 16'h0, "R8 unmapped 63");

    repeat (3) tick();
    check("R10 all reads seen", 48'(exp_q.size()), 48'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule